// File: doc/BRIEF.md
# Split-Transaction Master Tag Tracker

This block is the master end of a split-transaction memory bus. A user-side request (address, write flag, write data, byte mask) goes out on the control lines. The hub accepts it by raising its acknowledge and hands back a transaction tag. The tracker files the request under that tag. Later the hub calls tags, in any order. On a call of one of its own pending reads, the tracker takes the data the hub returns on the next cycle and hands it to the user, together with the request's address and tag. On a call of one of its own pending writes, it drives the stored write data and byte mask on the next cycle.

Outside that one data cycle, the write data and mask lines are held at exactly zero. The write-data lines of many masters can then be merged with a plain OR ahead of the memory controller. Only the masters track tags; the hub keeps no per-master data routing.

The strobe follows the user's valid signal directly, and the user's ready is the hub's acknowledge. A request can therefore be issued on every cycle that the hub acknowledges.

Top module: `tag_tracker`

## Requirements
- R1: `bus_stb`, `bus_adr` and `bus_we` equal `req_valid`, `req_addr` and `req_write` in the same cycle. `req_ready` equals `bus_ack` in the same cycle.
- R2: A request is accepted in a cycle where `req_valid` and `bus_ack` are both high. It is then recorded as pending under the value of `bus_tag_issue` in that cycle.
- R3: A call (`bus_call` high) of a tag that holds a pending read frees that tag. `bus_dat_r` is sampled in the next cycle and appears on `rsp_data` in the cycle after that, with `rsp_valid` high for one cycle. In that same cycle `rsp_addr` and `rsp_tag` carry the read's address and tag.
- R4: A call of a tag that holds a pending write frees that tag. In the next cycle `bus_dat_w` carries the stored write data and `bus_dat_wm` the stored mask. Mask bit i covers data bits 8i+7 down to 8i; a high bit means that byte is written.
- R5: In every cycle other than the one after a call of this master's own pending write, `bus_dat_w` and `bus_dat_wm` are all zeros.
- R6: `bus_dat_r` is never captured in the cycle after a write call: no `rsp_valid` results from it.
- R7: A call of a tag that is not pending has no effect. It produces no response and no write data, and it leaves every pending entry intact.
- R8: A tag can be issued again in the same cycle that it is called. The call completes the old transaction with its old contents, and the new request becomes pending under that tag.
- R9: Pending transactions complete in the order they are called, whatever order they were issued in.
- R10: While reset is asserted, and after it, until the first call, `rsp_valid` is low and `bus_dat_w` and `bus_dat_wm` are zero. Reset asserts asynchronously and is released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Request accepted this cycle (follows acknowledge) |
| req_addr | input | ADDR_W | Request word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_wmask | input | DATA_W/8 | Byte write mask |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | DATA_W | Read data |
| rsp_addr | output | ADDR_W | Address of the completed read |
| rsp_tag | output | TAG_W | Tag of the completed read |
| bus_stb | output | 1 | Request strobe to the hub |
| bus_adr | output | ADDR_W | Request address to the hub |
| bus_we | output | 1 | Request write flag to the hub |
| bus_ack | input | 1 | Hub acknowledge; issue tag valid |
| bus_tag_issue | input | TAG_W | Tag given to the request |
| bus_call | input | 1 | Hub calls a tag |
| bus_tag_call | input | TAG_W | Called tag |
| bus_dat_r | input | DATA_W | Read data, valid the cycle after a read call |
| bus_dat_w | output | DATA_W | Write data, zero outside own write data cycle |
| bus_dat_wm | output | DATA_W/8 | Write byte mask, zero outside own write data cycle |

## Verification
The hardest case is a tag reissued in the very cycle it is called, while its old write data still has to reach the bus one cycle later. Reaching it takes a hub model that offers, as the next issue tag, the exact tag it is calling in the same cycle. The bench's hub model does this on purpose, alongside calls of tags that are not pending and acknowledges given while no request is waiting. It also fills all tags, so that completion order departs widely from issue order.

// File: rtl/tt_pkg.sv
package tt_pkg;
  // Outcome of looking up a called tag in the table
  typedef enum logic [1:0] {
    CALL_NONE  = 2'd0,
    CALL_READ  = 2'd1,
    CALL_WRITE = 2'd2
  } call_kind_e;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tt_tag_table.sv
module tt_tag_table
  import tt_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_en,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              iss_we,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [DATA_W-1:0] iss_wdata,
  input  logic [MASK_W-1:0] iss_wmask,
  input  logic              call_en,
  input  logic [TAG_W-1:0]  call_tag,
  output call_kind_e        hit_kind,
  output logic [ADDR_W-1:0] hit_addr,
  output logic [DATA_W-1:0] hit_wdata,
  output logic [MASK_W-1:0] hit_wmask
);
  localparam int NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0] valid_q, valid_d, set_v, clr_v;
  logic             we_q   [NTAGS];
  logic [ADDR_W-1:0] addr_q [NTAGS];
  logic [DATA_W-1:0] data_q [NTAGS];
  logic [MASK_W-1:0] mask_q [NTAGS];

  // Per-entry occupancy: an issue into an entry wins over a call of it
  for (genvar e = 0; e < NTAGS; e++) begin : g_entry
    assign set_v[e]   = iss_en  && (iss_tag  == TAG_W'(e));
    assign clr_v[e]   = call_en && (call_tag == TAG_W'(e));
    assign valid_d[e] = set_v[e] | (valid_q[e] & ~clr_v[e]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Payload storage, no reset, written only on issue
  always_ff @(posedge clk) begin
    for (int e = 0; e < NTAGS; e++) begin
      if (set_v[e]) begin
        we_q[e]   <= iss_we;
        addr_q[e] <= iss_addr;
      end
      if (set_v[e] && iss_we) begin
        data_q[e] <= iss_wdata;
        mask_q[e] <= iss_wmask;
      end
    end
  end

  // Lookup of the called tag (old contents, before this cycle's issue)
  always_comb begin
    hit_kind  = CALL_NONE;
    hit_addr  = addr_q[call_tag];
    hit_wdata = data_q[call_tag];
    hit_wmask = mask_q[call_tag];
    if (call_en && valid_q[call_tag]) begin
      hit_kind = we_q[call_tag] ? CALL_WRITE : CALL_READ;
    end
  end
endmodule

// File: rtl/tt_data_stage.sv
module tt_data_stage
  import tt_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  call_kind_e        hit_kind,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [DATA_W-1:0] hit_wdata,
  input  logic [MASK_W-1:0] hit_wmask,
  input  logic [TAG_W-1:0]  call_tag,
  input  logic [DATA_W-1:0] bus_dat_r,
  output logic [DATA_W-1:0] dat_w,
  output logic [MASK_W-1:0] dat_wm,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [TAG_W-1:0]  rsp_tag
);
  logic [DATA_W-1:0] wd_q, wd_d;
  logic [MASK_W-1:0] wm_q, wm_d;
  logic              rd_pend_q, rd_pend_d;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [TAG_W-1:0]  rd_tag_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [ADDR_W-1:0] rsp_addr_q;
  logic [TAG_W-1:0]  rsp_tag_q;

  // Next state: write lanes are forced to zero unless an own write was called
  always_comb begin
    wd_d      = '0;
    wm_d      = '0;
    rd_pend_d = 1'b0;
    case (hit_kind)
      CALL_WRITE: begin
        wd_d = hit_wdata;
        wm_d = hit_wmask;
      end
      CALL_READ: rd_pend_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q        <= '0;
      wm_q        <= '0;
      rd_pend_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      wd_q        <= wd_d;
      wm_q        <= wm_d;
      rd_pend_q   <= rd_pend_d;
      rsp_valid_q <= rd_pend_q;
    end
  end

  // Enabled payload registers
  always_ff @(posedge clk) begin
    if (rd_pend_d) begin
      rd_addr_q <= hit_addr;
      rd_tag_q  <= call_tag;
    end
    if (rd_pend_q) begin
      rsp_data_q <= bus_dat_r;
      rsp_addr_q <= rd_addr_q;
      rsp_tag_q  <= rd_tag_q;
    end
  end

  assign dat_w     = wd_q;
  assign dat_wm    = wm_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_addr  = rsp_addr_q;
  assign rsp_tag   = rsp_tag_q;
endmodule

// File: rtl/tag_tracker.sv
module tag_tracker
  import tt_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_wmask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_data,
  output logic [ADDR_W-1:0]     rsp_addr,
  output logic [TAG_W-1:0]      rsp_tag,
  output logic                  bus_stb,
  output logic [ADDR_W-1:0]     bus_adr,
  output logic                  bus_we,
  input  logic                  bus_ack,
  input  logic [TAG_W-1:0]      bus_tag_issue,
  input  logic                  bus_call,
  input  logic [TAG_W-1:0]      bus_tag_call,
  input  logic [DATA_W-1:0]     bus_dat_r,
  output logic [DATA_W-1:0]     bus_dat_w,
  output logic [DATA_W/8-1:0]   bus_dat_wm
);
  localparam int MASK_W = DATA_W / 8;

  logic              rst_sync_n;
  logic              iss_en;
  call_kind_e        hit_kind;
  logic [ADDR_W-1:0] hit_addr;
  logic [DATA_W-1:0] hit_wdata;
  logic [MASK_W-1:0] hit_wmask;

  tt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Control path is a pass-through so a request can go every acknowledged cycle
  assign bus_stb   = req_valid;
  assign bus_adr   = req_addr;
  assign bus_we    = req_write;
  assign req_ready = bus_ack;
  assign iss_en    = req_valid & bus_ack;

  tt_tag_table #(
    .TAG_W (TAG_W), .ADDR_W (ADDR_W), .DATA_W (DATA_W), .MASK_W (MASK_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .iss_en    (iss_en),
    .iss_tag   (bus_tag_issue),
    .iss_we    (req_write),
    .iss_addr  (req_addr),
    .iss_wdata (req_wdata),
    .iss_wmask (req_wmask),
    .call_en   (bus_call),
    .call_tag  (bus_tag_call),
    .hit_kind  (hit_kind),
    .hit_addr  (hit_addr),
    .hit_wdata (hit_wdata),
    .hit_wmask (hit_wmask)
  );

  tt_data_stage #(
    .TAG_W (TAG_W), .ADDR_W (ADDR_W), .DATA_W (DATA_W), .MASK_W (MASK_W)
  ) u_data (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hit_kind  (hit_kind),
    .hit_addr  (hit_addr),
    .hit_wdata (hit_wdata),
    .hit_wmask (hit_wmask),
    .call_tag  (bus_tag_call),
    .bus_dat_r (bus_dat_r),
    .dat_w     (bus_dat_w),
    .dat_wm    (bus_dat_wm),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_addr  (rsp_addr),
    .rsp_tag   (rsp_tag)
  );
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int DATA_W = 32,
  parameter int MASK_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_call,
  input logic [DATA_W-1:0] bus_dat_w,
  input logic [MASK_W-1:0] bus_dat_wm,
  input logic              rsp_valid
);
  // R5
  wdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dat_w != '0) |-> $past(bus_call));

  // R5
  wmask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dat_wm != '0) |-> $past(bus_call));

  // R3
  rsp_after_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_call, 2));

  // R6
  no_capture_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dat_wm != '0) |=> !rsp_valid);

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (bus_dat_w == '0 && bus_dat_wm == '0 && !rsp_valid));
endmodule

bind tag_tracker tt_checker #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_call   (bus_call),
  .bus_dat_w  (bus_dat_w),
  .bus_dat_wm (bus_dat_wm),
  .rsp_valid  (rsp_valid)
);

// File: tb/tag_tracker_bench.sv
`timescale 1ns/1ps
module tag_tracker_bench;
  localparam int TAG_W  = 3;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int MASK_W = DATA_W / 8;
  localparam int NTAGS  = 1 << TAG_W;
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [MASK_W-1:0] req_wmask;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0] rsp_addr;
  logic [TAG_W-1:0]  rsp_tag;
  logic bus_stb, bus_we, bus_ack, bus_call;
  logic [ADDR_W-1:0] bus_adr;
  logic [TAG_W-1:0]  bus_tag_issue, bus_tag_call;
  logic [DATA_W-1:0] bus_dat_r, bus_dat_w;
  logic [MASK_W-1:0] bus_dat_wm;

  always #2 clk = ~clk;

  tag_tracker #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tag_tracker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_wmask(req_wmask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_addr(rsp_addr), .rsp_tag(rsp_tag),
    .bus_stb(bus_stb), .bus_adr(bus_adr), .bus_we(bus_we), .bus_ack(bus_ack),
    .bus_tag_issue(bus_tag_issue), .bus_call(bus_call), .bus_tag_call(bus_tag_call),
    .bus_dat_r(bus_dat_r), .bus_dat_w(bus_dat_w), .bus_dat_wm(bus_dat_wm)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int reissue_seen = 0;
  int stray_seen   = 0;

  // Behavioural model state
  bit                mv  [NTAGS];
  bit                mwe [NTAGS];
  logic [ADDR_W-1:0] ma  [NTAGS];
  logic [DATA_W-1:0] md  [NTAGS];
  logic [MASK_W-1:0] mm  [NTAGS];
  bit                rd_pend;
  logic [ADDR_W-1:0] rd_addr;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] exp_dw;
  logic [MASK_W-1:0] exp_wm;
  bit                exp_rv;
  logic [DATA_W-1:0] exp_rd;
  logic [ADDR_W-1:0] exp_ra;
  logic [TAG_W-1:0]  exp_rt;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTAGS; t++) mv[t] = 1'b0;
      rd_pend = 1'b0; exp_rv = 1'b0; exp_dw = '0; exp_wm = '0;
    end else begin
      exp_rv = rd_pend;
      if (rd_pend) begin
        exp_rd = bus_dat_r; exp_ra = rd_addr; exp_rt = rd_tag;
      end
      rd_pend = 1'b0; exp_dw = '0; exp_wm = '0;
      if (bus_call && mv[bus_tag_call]) begin
        if (mwe[bus_tag_call]) begin
          exp_dw = md[bus_tag_call]; exp_wm = mm[bus_tag_call];
        end else begin
          rd_pend = 1'b1; rd_addr = ma[bus_tag_call]; rd_tag = bus_tag_call;
        end
        mv[bus_tag_call] = 1'b0;
      end
      if (req_valid && bus_ack) begin
        mv[bus_tag_issue]  = 1'b1;
        mwe[bus_tag_issue] = req_write;
        ma[bus_tag_issue]  = req_addr;
        md[bus_tag_issue]  = req_wdata;
        mm[bus_tag_issue]  = req_wmask;
      end
    end
  end

  task automatic compare_regs();
    if (exp_wm == '0 && exp_dw == '0) begin
      check(bus_dat_w == '0, "R5", "dat_w idle", 64'(bus_dat_w), 64'(0));
      check(bus_dat_wm == '0, "R5", "dat_wm idle", 64'(bus_dat_wm), 64'(0));
    end else begin
      check(bus_dat_w == exp_dw, "R4 R2 R8", "dat_w", 64'(bus_dat_w), 64'(exp_dw));
      check(bus_dat_wm == exp_wm, "R4 R2", "dat_wm", 64'(bus_dat_wm), 64'(exp_wm));
    end
    check(rsp_valid == exp_rv, "R3 R6 R7", "rsp_valid", 64'(rsp_valid), 64'(exp_rv));
    if (exp_rv && rsp_valid) begin
      check(rsp_data == exp_rd, "R3 R9", "rsp_data", 64'(rsp_data), 64'(exp_rd));
      check(rsp_addr == exp_ra, "R3 R9", "rsp_addr", 64'(rsp_addr), 64'(exp_ra));
      check(rsp_tag == exp_rt, "R3 R9", "rsp_tag", 64'(rsp_tag), 64'(exp_rt));
    end
  endtask

  task automatic compare_comb();
    check(bus_stb == req_valid, "R1", "bus_stb", 64'(bus_stb), 64'(req_valid));
    check(bus_adr == req_addr, "R1", "bus_adr", 64'(bus_adr), 64'(req_addr));
    check(bus_we == req_write, "R1", "bus_we", 64'(bus_we), 64'(req_write));
    check(req_ready == bus_ack, "R1", "req_ready", 64'(req_ready), 64'(bus_ack));
  endtask

  task automatic drive_idle();
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_wmask = '0;
    bus_ack = 0; bus_tag_issue = '0; bus_call = 0; bus_tag_call = '0;
    bus_dat_r = $urandom;
  endtask

  // Hub model: calls pending tags out of order, sometimes stray tags,
  // sometimes reissues the tag it is calling in the same cycle
  task automatic drive_random(input int busy);
    int nfree, npend, pick;
    bit [TAG_W-1:0] free_t [$];
    bit [TAG_W-1:0] pend_t [$];
    for (int t = 0; t < NTAGS; t++) begin
      if (mv[t]) pend_t.push_back(TAG_W'(t)); else free_t.push_back(TAG_W'(t));
    end
    nfree = free_t.size(); npend = pend_t.size();
    bus_dat_r = $urandom;
    bus_call = 0; bus_tag_call = '0;
    if (npend > 0 && ($urandom % 100) < 45) begin
      pick = int'($urandom % npend);
      bus_call = 1; bus_tag_call = pend_t[pick];
    end else if (nfree > 0 && ($urandom % 100) < 10) begin
      pick = int'($urandom % nfree);
      bus_call = 1; bus_tag_call = free_t[pick];   // R7 stray call
      stray_seen++;
    end
    req_valid = (($urandom % 100) < busy);
    req_write = $urandom;
    req_addr  = ADDR_W'($urandom);
    req_wdata = $urandom;
    req_wmask = MASK_W'($urandom);
    bus_ack = 0; bus_tag_issue = '0;
    if (bus_call && mv[bus_tag_call] && ($urandom % 100) < 40) begin
      bus_ack = 1; bus_tag_issue = bus_tag_call;   // R8 same-cycle reissue
      if (req_valid) reissue_seen++;
    end else if (nfree > 0 && ($urandom % 100) < 70) begin
      pick = int'($urandom % nfree);
      bus_ack = 1; bus_tag_issue = free_t[pick];
    end
  endtask

  initial begin
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 64'(rsp_valid), 64'(0));
    check(bus_dat_w == '0, "R10", "dat_w in reset", 64'(bus_dat_w), 64'(0));
    check(bus_dat_wm == '0, "R10", "dat_wm in reset", 64'(bus_dat_wm), 64'(0));
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      compare_regs();
      drive_idle();
    end
    for (int c = 0; c < CYCLES; c++) begin
      @(negedge clk);
      compare_regs();
      drive_random(c < CYCLES / 2 ? 90 : 50);
      #1;
      compare_comb();
    end
    @(negedge clk);
    compare_regs();
    drive_idle();
    repeat (3) begin
      @(negedge clk);
      compare_regs();
    end
    check(reissue_seen > 0, "R8", "same-cycle reissue exercised", 64'(reissue_seen), 64'(1));
    check(stray_seen > 0, "R7", "stray call exercised", 64'(stray_seen), 64'(1));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule